// File: doc/BRIEF.md
# Saturating Bus Event Counter

This block counts one chosen kind of event seen by the arbiters of a bus crossbar. Each downstream port of the crossbar supplies two single-cycle strobes. One is high in a cycle when the port grants an access. The other is high when that port's arbiter saw more than one requester in the same cycle. A 5-bit selector picks one strobe from this set. A saturating counter then advances by one on every clock edge at which the chosen strobe is high.

Software reaches the block through a small register interface with separate read and write enables, a byte address and 32-bit data. The counter sits at offset 0x0 and reads zero-extended to 32 bits. Any write to offset 0x0 resets the counter, whatever the data. The selector sits at offset 0x4. After reset the selector holds a code that matches no event, so the counter stays at zero until software picks an event.

Top module: `bus_evt_counter`

## Requirements
- R1: After reset the selector reads 0x1F and the counter reads 0. With the reset selector value, strobe activity leaves the counter at 0.
- R2: Select code 2k counts the contested strobe of port k, and code 2k+1 counts the granted strobe of port k. Port k is bit k of `contest_strb` and of `grant_strb`. Ports 0 to 9 are, in order: APB, fast peripherals, SRAM5, SRAM4, SRAM3, SRAM2, SRAM1, SRAM0, XIP and ROM.
- R3: The counter increases by exactly one on each rising clock edge at which the selected strobe is high. Strobes that are not selected have no effect.
- R4: The counter saturates at its all-ones value (0xFFFFFF when it is 24 bits wide). Further events leave it at that value.
- R5: A write of any data to offset 0x0 sets the counter to zero. The written data is ignored.
- R6: If a clearing write and a selected event occur at the same edge, the counter reads zero afterwards.
- R7: Select codes 0x14 to 0x1F match no event. While one of them is selected, the counter does not change.
- R8: A new selector value applies from the edge after the write. The edge of the write itself still uses the old code. Changing the selector does not clear the counter.
- R9: A read samples the addressed value at the edge where `rd_en` is high and presents it on `rdata` after that edge. Offset 0x0 returns the counter with zero upper bits. Offset 0x4 returns the selector. Any other offset returns zero.
- R10: The selector stores bits 4:0 of the written data and ignores the upper bits. When read, the bits above the selector are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register being accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid after the edge that sampled `rd_en` |
| grant_strb | input | 10 | Per-port strobe: an access was granted this cycle |
| contest_strb | input | 10 | Per-port strobe: the arbiter saw more than one requester this cycle |

## Verification
A wrong selector decode shows as a count in the wrong place. Either the counter moves for a strobe that should not count, or it stays still for one that should. The fault appears at the next read of offset 0x0. A counter fault (wrapping, adding two, or losing a clear) changes the value read right after the edge concerned. A sweep over all 32 select codes against every single strobe catches such faults within a few hundred cycles. The bench uses a counter narrowed to 6 bits so that the saturation point is reached within about 64 cycles.

// File: rtl/bus_evt_counter.sv
module bus_evt_counter #(
  parameter int CNT_W   = 24,
  parameter int SEL_W   = 5,
  parameter int NPORTS  = 10,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter logic [SEL_W-1:0] SEL_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPORTS-1:0] grant_strb,
  input  logic [NPORTS-1:0] contest_strb
);

  localparam int NCODES = 2 * NPORTS;
  localparam int NSEL   = 1 << SEL_W;
  localparam logic [ADDR_W-1:0] CNT_OFF = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SEL_OFF = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt;
  logic [SEL_W-1:0]  sel;
  logic [NCODES-1:0] ev_pairs;
  logic [NSEL-1:0]   ev_vec;
  logic              ev_hit, clr, sel_wr;

  for (genvar k = 0; k < NPORTS; k++) begin : g_pair
    assign ev_pairs[2*k]   = contest_strb[k];
    assign ev_pairs[2*k+1] = grant_strb[k];
  end

  assign ev_vec = {{(NSEL-NCODES){1'b0}}, ev_pairs};
  assign ev_hit = ev_vec[sel];
  assign clr    = wr_en && addr == CNT_OFF;
  assign sel_wr = wr_en && addr == SEL_OFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sel <= SEL_RST;
    end else begin
      if (clr)
        cnt <= '0;
      else if (ev_hit && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
      if (sel_wr)
        sel <= wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en) begin
      if (addr == CNT_OFF)
        rdata <= DATA_W'(cnt);
      else if (addr == SEL_OFF)
        rdata <= DATA_W'(sel);
      else
        rdata <= '0;
    end
  end

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  // R7
  dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= SEL_W'(NCODES) && !clr) |=> $stable(cnt));

  // R8
  sel_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !clr) |=> cnt >= $past(cnt));

  // R10
  sel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SEL_OFF) |=> rdata[DATA_W-1:SEL_W] == '0);

endmodule

// File: tb/bus_evt_counter_bench.sv
module bus_evt_counter_bench;
  localparam int CW = 6;
  localparam int NP = 10;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata, got;
  logic [NP-1:0] grant_strb = 0, contest_strb = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_evt_counter #(.CNT_W(CW)) u_bus_evt_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .grant_strb(grant_strb), .contest_strb(contest_strb));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic drive(input logic [NP-1:0] g, input logic [NP-1:0] c, input int n);
    @(negedge clk); grant_strb = g; contest_strb = c;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); grant_strb = 0; contest_strb = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'h4, got); check("R1 sel reset", got, 32'h1F);
    rd(4'h0, got); check("R1 cnt reset", got, 0);
    drive('1, '1, 10);
    rd(4'h0, got); check("R1 no count at reset code", got, 0);

    // R2 R3 R7 sweep of all codes against every strobe
    for (int code = 0; code < 32; code++) begin
      wr(4'h4, code);
      wr(4'h0, 0);
      for (int j = 0; j < 2 * NP; j++) begin
        logic [NP-1:0] g, c;
        g = 0; c = 0;
        if (j % 2 == 1) g[j/2] = 1'b1; else c[j/2] = 1'b1;
        drive(g, c, j + 1);
      end
      drive('1, '1, 3);
      rd(4'h0, got);
      check(code < 2 * NP ? "R2 R3 code sweep" : "R7 dead code", got,
            code < 2 * NP ? code + 4 : 0);
    end

    // R5 clear with arbitrary data
    wr(4'h4, 1);
    drive(1, 0, 7);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, got); check("R5 clear ignores data", got, 0);

    // R4 saturation
    drive(1, 0, MAXV + 7);
    rd(4'h0, got); check("R4 saturate", got, MAXV);
    drive(1, 0, 5);
    rd(4'h0, got); check("R4 hold at max", got, MAXV);

    // R6 clear and event at the same edge
    @(negedge clk); grant_strb = 1; wr_en = 1; addr = 0; wdata = 0;
    @(negedge clk); grant_strb = 0; wr_en = 0;
    rd(4'h0, got); check("R6 clear wins", got, 0);

    // R8 selector change timing, no clear
    drive(1, 0, 4);
    @(negedge clk); grant_strb = 1; wr_en = 1; addr = 4; wdata = 3;
    @(negedge clk); wr_en = 0;
    repeat (2) @(negedge clk);
    grant_strb = 0;
    rd(4'h0, got); check("R8 old code at write edge, no clear", got, 5);
    rd(4'h4, got); check("R8 sel updated", got, 3);

    // R9 read latency and map
    @(negedge clk); rd_en = 1; addr = 0; grant_strb = 2;
    @(negedge clk); rd_en = 0; grant_strb = 0; got = rdata;
    check("R9 read samples pre-event value", got, 5);
    rd(4'h0, got); check("R9 next read sees event", got, 6);
    rd(4'h8, got); check("R9 unmapped reads zero", got, 0);
    rd(4'hC, got); check("R9 unmapped reads zero", got, 0);

    // R10 selector upper bits dropped
    wr(4'h4, 32'h7FFF_FFE3);
    rd(4'h4, got); check("R10 sel field only", got, 32'h03);
    rd(4'h0, got); check("R8 sel write keeps count", got, 6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule